// File: doc/BRIEF.md
# MAC Wake and Host Access Handshake

This block holds the general-purpose control word through which a host powers up the internal MAC, keeps it awake while it touches internal resources, and reads back the power state. The host writes two request flags, init-done and access-request, together with a crystal-on request and a sleep-delay field. A small sequencer walks the MAC through off, waking, awake, going-to-sleep and fault. Power-domain control sits outside the block and is reached through a wake request output and a power-up-complete input pulse.

Status returns through the same word: clock-ready, going-to-sleep, a 3-bit power-save code and the synchronized level of the external RF-kill switch. The `access_granted` output tells the host side when internal accesses are safe. `rfkill_change` is a one-cycle pulse on every change of the synchronized RF-kill level and serves as an interrupt cause. The internal firmware requests sleep by holding `sleep_req` high. The request is honoured only while the host is not asking for access.

Top module: `mac_wake_ctrl`

## Requirements
- R1: After reset the readback word is 0x0100_0000: every request flag is 0, clock-ready is 0, power-save code is 001 and `access_granted` and `wake_req` are low.
- R2: Clock-ready stays 0 while init-done (bit 2) is 0. One cycle after init-done is registered as 1, with either access-request set or `sleep_req` low, `wake_req` rises. Clock-ready (bit 0 and `clk_ready`) rises on the cycle after a `pwrup_done` pulse.
- R3: `access_granted` is high exactly when clock-ready is 1 and going-to-sleep (bit 4) is 0.
- R4: In the awake state, `sleep_req` high with access-request (bit 3) 0 raises going-to-sleep for D cycles, where D is the delay field at bits 23:16 and a value of 0 counts as 1. Clock-ready then drops. With access-request 1 the sleep request has no effect.
- R5: Setting access-request while the MAC is off starts a wake even while `sleep_req` is high.
- R6: Clearing init-done sends the MAC to the off state on the next cycle from any state. Clock-ready drops, `wake_req` drops and the power-save code returns to 001.
- R7: Power-save code at bits 26:24 is 000 when awake with RF-kill level 0, 010 when awake with RF-kill level 1, 001 when off, waking or going to sleep, and 011 in fault.
- R8: If `pwrup_done` does not arrive within WAKE_TIMEOUT cycles of waking, the block enters fault. Fault shows code 011, clock-ready 0 and `wake_req` 0, ignores `pwrup_done`, and lasts until init-done is cleared.
- R9: Bit 27 follows `rfkill_pin` after SYNC_STAGES clock edges. `rfkill_change` is high for exactly one cycle, the first cycle in which the new level shows in bit 27.
- R10: Writes store bits 2, 3 and 10 and the field 23:16. Written values of bits 0, 4 and 24 to 27 are ignored. All other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Write strobe for the control word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Readback of control and status word |
| sleep_req | input | 1 | Internal request to power the MAC down (level) |
| pwrup_done | input | 1 | One-cycle pulse: power-up sequence finished |
| rfkill_pin | input | 1 | Asynchronous RF-kill switch level |
| wake_req | output | 1 | Request to power domains to bring the MAC up |
| xtal_req | output | 1 | Crystal-on request from bit 10 |
| clk_ready | output | 1 | MAC clock is ready |
| going_sleep | output | 1 | MAC is entering power-down |
| access_granted | output | 1 | Host may access internal resources |
| pwr_save_type | output | 3 | Current power-save code |
| rfkill_change | output | 1 | One-cycle pulse on RF-kill level change |

## Verification
A wrong sequencer state shows at the ports on the very next cycle. It appears as clock-ready or `wake_req` at the wrong level, or as a power-save code that disagrees with them. A miscounted sleep delay shows as going-to-sleep held one cycle too long or too short. A miscounted wake timeout moves the 011 code by one cycle. An RF-kill synchronizer of the wrong depth shifts bit 27 and the change pulse by one cycle, so the bench samples those signals on the exact cycle the requirement names.

// File: rtl/mwk_pkg.sv
package mwk_pkg;

  typedef enum logic [2:0] {
    SEQ_OFF      = 3'd0,
    SEQ_WAKING   = 3'd1,
    SEQ_AWAKE    = 3'd2,
    SEQ_SLEEPING = 3'd3,
    SEQ_FAULT    = 3'd4
  } seq_state_e;

  // bit positions inside the control word (host software decodes these)
  localparam int POS_CLK_RDY = 0;
  localparam int POS_INIT    = 2;
  localparam int POS_ACC     = 3;
  localparam int POS_GTS     = 4;
  localparam int POS_XTAL    = 10;
  localparam int POS_DLY     = 16;
  localparam int POS_PST     = 24;
  localparam int POS_RFK     = 27;

  localparam logic [2:0] PST_NONE  = 3'b000;
  localparam logic [2:0] PST_MAC   = 3'b001;
  localparam logic [2:0] PST_RADIO = 3'b010;
  localparam logic [2:0] PST_ERR   = 3'b011;

  // power-save code seen by the host for a sequencer state
  function automatic logic [2:0] pst_code(seq_state_e st, logic rfk);
    case (st)
      SEQ_AWAKE: pst_code = rfk ? PST_RADIO : PST_NONE;
      SEQ_FAULT: pst_code = PST_ERR;
      default:   pst_code = PST_MAC;
    endcase
  endfunction

  // number of going-to-sleep cycles for a programmed delay
  function automatic logic [31:0] sleep_len(logic [31:0] dly);
    sleep_len = (dly == 32'd0) ? 32'd1 : dly;
  endfunction

  // clock-ready is high whenever the MAC clock runs
  function automatic logic clk_on(seq_state_e st);
    clk_on = (st == SEQ_AWAKE) || (st == SEQ_SLEEPING);
  endfunction

endpackage

// File: rtl/mwk_sync.sv
module mwk_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic level,
  output logic change
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= pin;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], pin};
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= chain_q[STAGES-1];
  end

  assign level  = chain_q[STAGES-1];
  assign change = chain_q[STAGES-1] ^ prev_q;
endmodule

// File: rtl/mwk_ctrl_reg.sv
module mwk_ctrl_reg
  import mwk_pkg::*;
#(
  parameter int unsigned DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [31:0]      wdata,
  input  logic             clk_ready,
  input  logic             going_sleep,
  input  logic [2:0]       pst,
  input  logic             rfk_level,
  output logic             init_done,
  output logic             acc_req,
  output logic             xtal_req,
  output logic [DLY_W-1:0] slp_dly,
  output logic [31:0]      rdata
);
  localparam logic [31:0] DLY_MASK = ((32'd1 << DLY_W) - 32'd1) << POS_DLY;
  localparam logic [31:0] WR_MASK  = DLY_MASK | (32'd1 << POS_INIT) |
                                     (32'd1 << POS_ACC) | (32'd1 << POS_XTAL);

  logic unused_wdata;
  assign unused_wdata = ^(wdata & ~WR_MASK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      init_done <= 1'b0;
      acc_req   <= 1'b0;
      xtal_req  <= 1'b0;
      slp_dly   <= '0;
    end else if (wr) begin
      init_done <= wdata[POS_INIT];
      acc_req   <= wdata[POS_ACC];
      xtal_req  <= wdata[POS_XTAL];
      slp_dly   <= wdata[POS_DLY +: DLY_W];
    end
  end

  always_comb begin
    rdata                     = '0;
    rdata[POS_CLK_RDY]        = clk_ready;
    rdata[POS_INIT]           = init_done;
    rdata[POS_ACC]            = acc_req;
    rdata[POS_GTS]            = going_sleep;
    rdata[POS_XTAL]           = xtal_req;
    rdata[POS_DLY +: DLY_W]   = slp_dly;
    rdata[POS_PST +: 3]       = pst;
    rdata[POS_RFK]            = rfk_level;
  end
endmodule

// File: rtl/mwk_seq.sv
module mwk_seq
  import mwk_pkg::*;
#(
  parameter int unsigned DLY_W        = 8,
  parameter int unsigned WAKE_TIMEOUT = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             init_done,
  input  logic             acc_req,
  input  logic             sleep_req,
  input  logic             pwrup_done,
  input  logic             rfk_level,
  input  logic [DLY_W-1:0] slp_dly,
  output logic             clk_ready,
  output logic             going_sleep,
  output logic             wake_req,
  output logic [2:0]       pst,
  output logic             sleep_enter,
  output logic             wake_timeout
);
  localparam int unsigned WK_CW = $clog2(WAKE_TIMEOUT + 1);
  localparam logic [WK_CW-1:0] WK_LAST = WK_CW'(WAKE_TIMEOUT - 1);

  seq_state_e       st_q, st_d;
  logic [WK_CW-1:0] wk_cnt_q;
  logic [DLY_W-1:0] slp_cnt_q;
  logic [DLY_W-1:0] slp_load;
  logic             sleep_last;

  assign slp_load   = DLY_W'(sleep_len(32'(slp_dly)));
  assign sleep_last = (slp_cnt_q == DLY_W'(1));

  always_comb begin
    st_d = st_q;
    case (st_q)
      SEQ_OFF:
        if (init_done && (acc_req || !sleep_req)) st_d = SEQ_WAKING;
      SEQ_WAKING:
        if (!init_done)                st_d = SEQ_OFF;
        else if (pwrup_done)           st_d = SEQ_AWAKE;
        else if (wk_cnt_q == WK_LAST)  st_d = SEQ_FAULT;
      SEQ_AWAKE:
        if (!init_done)                st_d = SEQ_OFF;
        else if (sleep_req && !acc_req) st_d = SEQ_SLEEPING;
      SEQ_SLEEPING:
        if (!init_done || sleep_last)  st_d = SEQ_OFF;
      SEQ_FAULT:
        if (!init_done)                st_d = SEQ_OFF;
      default:                         st_d = SEQ_OFF;
    endcase
  end

  assign sleep_enter  = (st_q == SEQ_AWAKE)  && (st_d == SEQ_SLEEPING);
  assign wake_timeout = (st_q == SEQ_WAKING) && (st_d == SEQ_FAULT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= SEQ_OFF;
      wk_cnt_q  <= '0;
      slp_cnt_q <= '0;
    end else begin
      st_q <= st_d;
      if (st_q == SEQ_WAKING && st_d == SEQ_WAKING) wk_cnt_q <= wk_cnt_q + WK_CW'(1);
      else                                          wk_cnt_q <= '0;
      if (sleep_enter)               slp_cnt_q <= slp_load;
      else if (st_q == SEQ_SLEEPING) slp_cnt_q <= slp_cnt_q - DLY_W'(1);
    end
  end

  assign clk_ready   = clk_on(st_q);
  assign going_sleep = (st_q == SEQ_SLEEPING);
  assign wake_req    = (st_q == SEQ_WAKING);
  assign pst         = pst_code(st_q, rfk_level);
endmodule

// File: rtl/mac_wake_ctrl.sv
module mac_wake_ctrl
  import mwk_pkg::*;
#(
  parameter int unsigned DLY_W        = 8,
  parameter int unsigned WAKE_TIMEOUT = 64,
  parameter int unsigned SYNC_STAGES  = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        sleep_req,
  input  logic        pwrup_done,
  input  logic        rfkill_pin,
  output logic        wake_req,
  output logic        xtal_req,
  output logic        clk_ready,
  output logic        going_sleep,
  output logic        access_granted,
  output logic [2:0]  pwr_save_type,
  output logic        rfkill_change
);
  // DLY_W must keep the delay field below bit 24
  logic             init_done_w, acc_req_w, rfk_level_w;
  logic [DLY_W-1:0] slp_dly_w;
  logic             sleep_enter_w, wake_timeout_w;

  mwk_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin(rfkill_pin),
    .level(rfk_level_w), .change(rfkill_change)
  );

  mwk_seq #(.DLY_W(DLY_W), .WAKE_TIMEOUT(WAKE_TIMEOUT)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .init_done(init_done_w), .acc_req(acc_req_w),
    .sleep_req(sleep_req), .pwrup_done(pwrup_done),
    .rfk_level(rfk_level_w), .slp_dly(slp_dly_w),
    .clk_ready(clk_ready), .going_sleep(going_sleep),
    .wake_req(wake_req), .pst(pwr_save_type),
    .sleep_enter(sleep_enter_w), .wake_timeout(wake_timeout_w)
  );

  mwk_ctrl_reg #(.DLY_W(DLY_W)) u_reg (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .wdata(reg_wdata),
    .clk_ready(clk_ready), .going_sleep(going_sleep),
    .pst(pwr_save_type), .rfk_level(rfk_level_w),
    .init_done(init_done_w), .acc_req(acc_req_w),
    .xtal_req(xtal_req), .slp_dly(slp_dly_w), .rdata(reg_rdata)
  );

  assign access_granted = clk_ready && !going_sleep;
endmodule

// File: rtl/mwk_checker.sv
module mwk_checker (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] reg_rdata,
  input logic        clk_ready,
  input logic        going_sleep,
  input logic        access_granted,
  input logic        wake_req,
  input logic [2:0]  pwr_save_type,
  input logic        rfkill_change,
  input logic        sleep_enter,
  input logic        wake_timeout
);
  assert_grant_R3: assert property (@(posedge clk) disable iff (!rst_n)
    access_granted |-> (reg_rdata[0] && !reg_rdata[4]));

  assert_no_init_no_clock_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rdata[2] |=> !clk_ready);

  assert_wake_before_clock_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req |-> !clk_ready);

  assert_sleep_needs_no_access_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_enter |-> !reg_rdata[3]);

  assert_sleep_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_enter |=> going_sleep);

  assert_sleep_end_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(going_sleep) |-> !clk_ready);

  assert_awake_code_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clk_ready && !going_sleep |-> (!pwr_save_type[0] && !pwr_save_type[2]));

  assert_fault_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wake_timeout |=> (pwr_save_type == 3'b011 && !clk_ready && !wake_req));

  assert_rfk_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rfkill_change |-> (reg_rdata[27] != $past(reg_rdata[27])));
endmodule

bind mac_wake_ctrl mwk_checker u_mwk_checker (
  .clk(clk), .rst_n(rst_n), .reg_rdata(reg_rdata),
  .clk_ready(clk_ready), .going_sleep(going_sleep),
  .access_granted(access_granted), .wake_req(wake_req),
  .pwr_save_type(pwr_save_type), .rfkill_change(rfkill_change),
  .sleep_enter(sleep_enter_w), .wake_timeout(wake_timeout_w)
);

// File: tb/mac_wake_ctrl_bench.sv
module mac_wake_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        sleep_req = 1'b0, pwrup_done = 1'b0, rfkill_pin = 1'b0;
  logic        wake_req, xtal_req, clk_ready, going_sleep, access_granted, rfkill_change;
  logic [2:0]  pwr_save_type;

  int n_checks = 0;
  int n_fails  = 0;

  always #10 clk = ~clk;

  mac_wake_ctrl u_mac_wake_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .sleep_req(sleep_req), .pwrup_done(pwrup_done),
    .rfkill_pin(rfkill_pin), .wake_req(wake_req), .xtal_req(xtal_req),
    .clk_ready(clk_ready), .going_sleep(going_sleep),
    .access_granted(access_granted), .pwr_save_type(pwr_save_type),
    .rfkill_change(rfkill_change)
  );

  // {write data, expected readback}, all with init-done 0 so the MAC stays off (R10)
  localparam logic [63:0] VEC [5] = '{
    {32'h0000_0000, 32'h0100_0000},
    {32'hFFFF_FFFB, 32'h01FF_0408},
    {32'h0000_0411, 32'h0100_0400},
    {32'h00A5_0008, 32'h01A5_0008},
    {32'h0F00_0001, 32'h0100_0000}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [31:0] d);
    reg_wr = 1'b1; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic pulse_pwrup();
    pwrup_done = 1'b1;
    @(negedge clk);
    pwrup_done = 1'b0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
    $finish;
  endtask

  initial begin
    #(200000 * 20);
    n_checks++; n_fails++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    // R1 reset state
    check("R1 rdata", reg_rdata, 32'h0100_0000);
    check("R1 ready/grant/wake", {29'd0, clk_ready, access_granted, wake_req}, 32'd0);
    check("R1 code", 32'(pwr_save_type), 32'd1);

    // R10 register layout via vector table
    for (int i = 0; i < 5; i++) begin
      wr(VEC[i][63:32]);
      check("R10 readback", reg_rdata, VEC[i][31:0]);
      check("R2 no clock without init", 32'(clk_ready), 32'd0);
    end
    wr(32'h0);
    step(3);
    check("R2 still off", {30'd0, clk_ready, wake_req}, 32'd0);

    // R2 wake sequence
    wr(32'h0000_0004);
    check("R2 not yet waking", 32'(wake_req), 32'd0);
    step(1);
    check("R2 wake_req", {30'd0, wake_req, clk_ready}, 32'b10);
    pulse_pwrup();
    check("R2 clock ready", 32'(clk_ready), 32'd1);
    check("R3 grant awake", 32'(access_granted), 32'd1);
    check("R7 code awake", 32'(pwr_save_type), 32'd0);

    // R9 / R7 rf-kill
    rfkill_pin = 1'b1;
    step(1);
    check("R9 one stage in", 32'(reg_rdata[27]), 32'd0);
    step(1);
    check("R9 level", {30'd0, reg_rdata[27], rfkill_change}, 32'b11);
    step(1);
    check("R9 pulse one cycle", 32'(rfkill_change), 32'd0);
    check("R7 radio code", 32'(pwr_save_type), 32'd2);
    rfkill_pin = 1'b0;
    step(2);
    check("R9 falling", {30'd0, reg_rdata[27], rfkill_change}, 32'b01);
    step(1);
    check("R9 fall pulse ends", 32'(rfkill_change), 32'd0);
    check("R7 back to none", 32'(pwr_save_type), 32'd0);

    // R4 sleep with delay 3
    wr(32'h0003_0004);
    sleep_req = 1'b1;
    step(1);
    check("R4 going", {29'd0, going_sleep, clk_ready, access_granted}, 32'b110);
    check("R7 code while sleeping", 32'(pwr_save_type), 32'd1);
    step(2);
    check("R4 going last", 32'(going_sleep), 32'd1);
    step(1);
    check("R4 asleep", {30'd0, going_sleep, clk_ready}, 32'd0);
    check("R4 asleep code", 32'(pwr_save_type), 32'd1);
    step(3);
    check("R4 stays asleep", {30'd0, clk_ready, wake_req}, 32'd0);

    // R5 access request wakes despite sleep_req
    wr(32'h0003_000C);
    step(1);
    check("R5 wake on access", 32'(wake_req), 32'd1);
    pulse_pwrup();
    check("R5 awake", 32'(clk_ready), 32'd1);
    step(5);
    check("R4 sleep ignored under access", {30'd0, going_sleep, clk_ready}, 32'b01);

    // R4 delay 0 counts as one cycle
    wr(32'h0000_0004);
    step(1);
    check("R4 zero delay going", 32'(going_sleep), 32'd1);
    step(1);
    check("R4 zero delay done", {30'd0, going_sleep, clk_ready}, 32'd0);

    // R6 clearing init-done from awake
    sleep_req = 1'b0;
    step(1);
    check("R6 rewake", 32'(wake_req), 32'd1);
    pulse_pwrup();
    check("R6 awake", 32'(clk_ready), 32'd1);
    wr(32'h0);
    step(1);
    check("R6 off", {30'd0, clk_ready, wake_req}, 32'd0);
    check("R6 code", 32'(pwr_save_type), 32'd1);
    step(3);
    check("R2 off without init", 32'(clk_ready), 32'd0);

    // R6 clearing init-done while waking
    wr(32'h0000_0004);
    step(1);
    check("R6 waking", 32'(wake_req), 32'd1);
    wr(32'h0);
    step(1);
    check("R6 abort wake", 32'(wake_req), 32'd0);

    // R8 wake timeout
    wr(32'h0000_0004);
    step(1);
    check("R8 waking", 32'(wake_req), 32'd1);
    step(63);
    check("R8 last waking cycle", {29'd0, wake_req, pwr_save_type[1:0]}, 32'b101);
    step(1);
    check("R8 fault", {28'd0, pwr_save_type, wake_req}, 32'b0110);
    check("R8 fault no clock", 32'(clk_ready), 32'd0);
    pulse_pwrup();
    step(1);
    check("R8 pwrup ignored", {28'd0, pwr_save_type, clk_ready}, 32'b0110);
    wr(32'h0);
    step(1);
    check("R8 fault cleared", 32'(pwr_save_type), 32'd1);

    finish_run();
  end
endmodule